// File: doc/BRIEF.md
# Result-Latency Register Interlock Scoreboard

This block keeps one countdown for each architectural register. The countdown shows how many cycles remain before the result being written to that register can be read. When an operation issues, the block looks up a fixed result latency from the operation's class and its width or precision mode. It loads that latency into the countdown of the destination register. Every countdown then falls by one per cycle until it reaches zero, and at zero the register is ready.

The issue stage also presents the source register numbers of the next operation, each with its own valid bit. The block raises a stall while any valid source names a register whose countdown is still running.

The block does not forward results, store register values or decide how operations are paired. Its only job is the interlock.

Top module: `rlat_scoreboard`

## Requirements
- R1: After reset every countdown is zero, and `stall` stays low whatever the sources are.
- R2: Classes 0 (simple integer ops), 1 (store) and 8 (read from HI/LO) have latency 1. After an issue in cycle k, a valid source naming the destination stalls for exactly 1 cycle.
- R3: Classes 2 (load, including float load) and 3 (integer/float register move) have latency 2.
- R4: Class 4 (multiply or multiply-add into HI/LO) has latency 5 when `iss_wide`=0 and 9 when `iss_wide`=1. Class 5 (three-operand multiply) has latency 2 when `iss_wide`=0 and 9 when `iss_wide`=1.
- R5: Class 6 (integer divide) has latency 36 when `iss_wide`=0 and 68 when `iss_wide`=1.
- R6: Classes 7 (write to HI/LO) and 9 (branch, jump, call) have latency 3.
- R7: Class 10 (float negate, compare, absolute value, move, add, convert) has latency 4. Class 11 (float multiply) has latency 4 in single precision (`iss_wide`=0) and 5 in double precision.
- R8: Class 12 (float divide or sqrt) has latency 21 single and 36 double. Class 13 (float reciprocal sqrt) has latency 38 single and 68 double. Codes 14 and 15 have latency 1.
- R9: An issue to a register whose countdown is still running replaces the countdown with the new latency, whether the new latency is shorter or longer.
- R10: A source whose valid bit is low never causes a stall, even when it names a busy register.
- R11: Countdowns of different registers run independently. `stall` is high if any one valid source, in any source slot, names a busy register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation issues this cycle |
| iss_class | input | 4 | Operation class code (see requirements) |
| iss_wide | input | 1 | 0: 32-bit or single precision; 1: 64-bit or double precision |
| iss_dest | input | REG_W (5) | Destination register of the issuing operation |
| src_valid | input | NSRC (2) | Per-slot valid bits for the next operation's sources |
| src_reg | input | NSRC*REG_W (10) | Source register numbers; slot s occupies bits [s*REG_W +: REG_W] |
| stall | output | 1 | High while a valid source names a register that is not ready |

## Verification
The hardest situation to reach is the replacement of a countdown that is still running. To produce it, the stimulus issues a long divide to a register, lets a few cycles pass, and then issues a short operation to the same register. It then counts the stall cycles that remain, and also runs the reverse case, where a short latency is replaced by a long one. Every class and mode is measured by pointing source slot 0 at the destination and counting the stall cycles. Separate sequences cover a busy register named through an invalid slot and through the second slot.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int LAT_W = 7;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_INT     = 4'd0,
    CL_STORE   = 4'd1,
    CL_LOAD    = 4'd2,
    CL_XFER    = 4'd3,
    CL_MULHL   = 4'd4,
    CL_MUL3    = 4'd5,
    CL_DIV     = 4'd6,
    CL_MTHL    = 4'd7,
    CL_MFHL    = 4'd8,
    CL_BRANCH  = 4'd9,
    CL_FPSIMP  = 4'd10,
    CL_FPMUL   = 4'd11,
    CL_FPDIV   = 4'd12,
    CL_FPRSQ   = 4'd13,
    CL_RES14   = 4'd14,
    CL_RES15   = 4'd15
  } op_class_e;

  // Result latency, in cycles, for a class and mode.
  function automatic logic [LAT_W-1:0] class_latency(input op_class_e cls, input logic wide);
    logic [LAT_W-1:0] l;
    case (cls)
      CL_INT, CL_STORE, CL_MFHL: l = 7'd1;
      CL_LOAD, CL_XFER:          l = 7'd2;
      CL_MTHL, CL_BRANCH:        l = 7'd3;
      CL_MULHL:                  l = wide ? 7'd9  : 7'd5;
      CL_MUL3:                   l = wide ? 7'd9  : 7'd2;
      CL_DIV:                    l = wide ? 7'd68 : 7'd36;
      CL_FPSIMP:                 l = 7'd4;
      CL_FPMUL:                  l = wide ? 7'd5  : 7'd4;
      CL_FPDIV:                  l = wide ? 7'd36 : 7'd21;
      CL_FPRSQ:                  l = wide ? 7'd68 : 7'd38;
      default:                   l = 7'd1;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/sb_latency.sv
module sb_latency
  import sb_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             wide,
  output logic [LAT_W-1:0] lat
);

  always_comb begin
    lat = class_latency(op_class_e'(cls), wide);
  end

  // Every class must give a usable, nonzero latency (R2, R8).
  always_comb begin
    assert_lat_nonzero_R8: assert (lat != '0);
  end

endmodule

// File: rtl/sb_reg_counter.sv
module sb_reg_counter
  import sb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] lat_in,
  output logic             busy
);

  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= lat_in;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // A load replaces whatever was running.
  assert_load_replaces_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(lat_in));

  // Without a load, a running countdown steps down by one.
  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // An idle register stays idle until something is issued to it.
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/sb_stall_detect.sv
module sb_stall_detect #(
  parameter int NREGS = 32,
  parameter int NSRC  = 2,
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0]      reg_busy,
  input  logic [NSRC-1:0]       src_valid,
  input  logic [NSRC*REG_W-1:0] src_reg,
  output logic [NSRC-1:0]       src_blocked,
  output logic                  stall
);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [REG_W-1:0] idx;
    assign idx            = src_reg[s*REG_W +: REG_W];
    assign src_blocked[s] = src_valid[s] && reg_busy[idx];
  end

  assign stall = |src_blocked;

endmodule

// File: rtl/rlat_scoreboard.sv
module rlat_scoreboard
  import sb_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int NSRC  = 2,
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_valid,
  input  logic [CLS_W-1:0]      iss_class,
  input  logic                  iss_wide,
  input  logic [REG_W-1:0]      iss_dest,
  input  logic [NSRC-1:0]       src_valid,
  input  logic [NSRC*REG_W-1:0] src_reg,
  output logic                  stall
);

  logic [LAT_W-1:0] iss_lat;
  logic [NREGS-1:0] issue_hit;
  logic [NREGS-1:0] reg_busy;
  logic [NSRC-1:0]  src_blocked;

  sb_latency u_lat (
    .cls  (iss_class),
    .wide (iss_wide),
    .lat  (iss_lat)
  );

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    assign issue_hit[r] = iss_valid && (iss_dest == REG_W'(r));
    sb_reg_counter u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (issue_hit[r]),
      .lat_in (iss_lat),
      .busy   (reg_busy[r])
    );
  end

  sb_stall_detect #(.NREGS(NREGS), .NSRC(NSRC)) u_stall (
    .reg_busy    (reg_busy),
    .src_valid   (src_valid),
    .src_reg     (src_reg),
    .src_blocked (src_blocked),
    .stall       (stall)
  );

  // Exactly one register takes each issue.
  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> $onehot0(issue_hit) && (issue_hit != '0));

  // The destination is busy in the cycle after issue.
  assert_issue_marks_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> reg_busy[$past(iss_dest)]);

  // Sources without a valid bit never stall.
  assert_invalid_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid == '0) |-> !stall);

endmodule

// File: tb/sim_rlat_scoreboard.sv
module sim_rlat_scoreboard;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 32;
  localparam int NSRC  = 2;
  localparam int REG_W = 5;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  iss_valid = 1'b0;
  logic [3:0]            iss_class = '0;
  logic                  iss_wide = 1'b0;
  logic [REG_W-1:0]      iss_dest = '0;
  logic [NSRC-1:0]       src_valid = '0;
  logic [NSRC*REG_W-1:0] src_reg = '0;
  logic                  stall;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int exp_q[$];

  rlat_scoreboard u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_wide(iss_wide), .iss_dest(iss_dest), .src_valid(src_valid),
    .src_reg(src_reg), .stall(stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below 60000", cyc);
      summary_and_end();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: issue one operation and queue the stall length the requirements give.
  task automatic drive_issue(input int cls, input bit wide, input int dest, input int exp_len);
    @(negedge clk);
    iss_valid = 1'b1;
    iss_class = 4'(cls);
    iss_wide  = wide;
    iss_dest  = REG_W'(dest);
    src_valid = 2'b01;
    src_reg   = {REG_W'(0), REG_W'(dest)};
    exp_q.push_back(exp_len);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  // Monitor: count stall cycles from the sample after issue and compare.
  task automatic monitor_len(input string req);
    int n = 0;
    int e;
    while (stall && n < 200) begin
      n++;
      @(negedge clk);
    end
    e = exp_q.pop_front();
    check(req, n, e);
  endtask

  task automatic measure(input string req, input int cls, input bit wide, input int dest, input int exp_len);
    drive_issue(cls, wide, dest, exp_len);
    monitor_len(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every register ready out of reset
    for (int r = 0; r < NREGS; r += 2) begin
      src_valid = 2'b11;
      src_reg   = {REG_W'(r + 1), REG_W'(r)};
      #1;
      check("R1", int'(stall), 0);
    end

    measure("R2", 0, 1'b0, 1, 1);
    measure("R2", 1, 1'b1, 2, 1);
    measure("R2", 8, 1'b0, 3, 1);
    measure("R3", 2, 1'b0, 4, 2);
    measure("R3", 3, 1'b1, 5, 2);
    measure("R4", 4, 1'b0, 6, 5);
    measure("R4", 4, 1'b1, 7, 9);
    measure("R4", 5, 1'b0, 8, 2);
    measure("R4", 5, 1'b1, 9, 9);
    measure("R5", 6, 1'b0, 10, 36);
    measure("R5", 6, 1'b1, 11, 68);
    measure("R6", 7, 1'b0, 12, 3);
    measure("R6", 9, 1'b1, 13, 3);
    measure("R7", 10, 1'b0, 14, 4);
    measure("R7", 11, 1'b0, 15, 4);
    measure("R7", 11, 1'b1, 16, 5);
    measure("R8", 12, 1'b0, 17, 21);
    measure("R8", 12, 1'b1, 18, 36);
    measure("R8", 13, 1'b0, 19, 38);
    measure("R8", 13, 1'b1, 20, 68);
    measure("R8", 14, 1'b0, 21, 1);
    measure("R8", 15, 1'b1, 22, 1);

    // R9: long divide replaced by a short op after a few cycles
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd6; iss_wide = 1'b0; iss_dest = 5'd5;
    src_valid = 2'b00;
    @(negedge clk);
    iss_valid = 1'b0;
    repeat (3) @(negedge clk);
    measure("R9", 0, 1'b0, 5, 1);
    // R9: short op replaced by a long one
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd10; iss_wide = 1'b0; iss_dest = 5'd6;
    src_valid = 2'b00;
    @(negedge clk);
    iss_valid = 1'b0;
    @(negedge clk);
    measure("R9", 12, 1'b0, 6, 21);

    // R10: invalid source naming a busy register
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd6; iss_wide = 1'b0; iss_dest = 5'd7;
    src_valid = 2'b00;
    src_reg   = {REG_W'(7), REG_W'(7)};
    @(negedge clk);
    iss_valid = 1'b0;
    check("R10", int'(stall), 0);
    src_valid = 2'b01;
    #1;
    check("R10", int'(stall), 1);
    src_valid = 2'b00;

    // R11: second slot sees r7 busy while slot 0 names a ready register
    src_valid = 2'b11;
    src_reg   = {REG_W'(7), REG_W'(30)};
    #1;
    check("R11", int'(stall), 1);
    // R11: independent countdowns, r8 (2) issued while r7 divide runs
    @(negedge clk);
    iss_valid = 1'b1; iss_class = 4'd2; iss_wide = 1'b0; iss_dest = 5'd8;
    src_valid = 2'b01; src_reg = {REG_W'(0), REG_W'(8)};
    @(negedge clk);
    iss_valid = 1'b0;
    check("R11", int'(stall), 1);
    @(negedge clk);
    check("R11", int'(stall), 1);
    @(negedge clk);
    check("R11", int'(stall), 0);
    src_valid = 2'b10; src_reg = {REG_W'(7), REG_W'(8)};
    #1;
    check("R11", int'(stall), 1);
    repeat (40) @(negedge clk);
    check("R11", int'(stall), 0);

    summary_and_end();
  end

endmodule